// File: doc/BRIEF.md
# Bit-Toggle Interval Timer

This block is a free-running up-counter that advances once for each pulse of a low-frequency tick enable and raises a periodic interrupt each time a chosen counter bit goes from 0 to 1. A select field names that bit. Selecting bit k gives one interrupt every 2^(k+1) ticks. No compare value is involved, and the block has no path that could reset the system. Its only output event is the interrupt flag.

Software controls the timer through a request level and a status line. A change to the request reaches the counter only after a fixed number of ticks, and the status line shows the state the counter is really in. The select field can be written only while the status reads stopped. A write made while the counter is running is dropped, so software must poll the status low before it changes the interval. The interrupt flag stays set until software pulses a clear. A new edge that lands in the same cycle as the clear wins.

Top module: `bit_toggle_timer`

## Requirements
- R1: After reset the count reads 0, the status reads 0, the select reads 0 and the interrupt is low.
- R2: When the run request goes from 0 to 1, the status rises after exactly SYNC_LAT (default 2) tick pulses. The counter first advances on the tick after that.
- R3: When the run request drops, the status stays high for SYNC_LAT further ticks. The counter keeps advancing on those ticks and then holds.
- R4: While the status is high, the counter advances by exactly 1 on every clock in which the tick enable is 1. It holds its value on clocks without a tick and whenever the status is low.
- R5: The counter wraps from all ones to zero.
- R6: With select value k (0 to CNT_W-1), the interrupt sets on the clock in which counter bit k goes from 0 to 1. It never sets when bit k falls or stays the same.
- R7: The interrupt stays set until irq_clr is 1 on a clock edge. If a rising edge of the selected bit falls in the same cycle as irq_clr, the flag remains set.
- R8: A write to the select (sel_wr=1) is ignored while the status is 1. While the status is 0 the write is taken on that clock, and the select readback shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | One-cycle low-frequency tick enable |
| run_req | input | 1 | Requested running state (level) |
| run_status | output | 1 | Actual running state of the counter |
| sel_wr | input | 1 | Select write strobe |
| sel_wdata | input | SEL_W | New bit-select value |
| sel_rdata | output | SEL_W | Current bit-select value |
| count_rdata | output | CNT_W | Current counter value |
| irq_clr | input | 1 | Interrupt clear pulse |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A fault in the synchronizer stages would show on run_status within SYNC_LAT ticks of a request change. The count would also be off by one or more within that window. A wrong select register, or a write that slipped through while running, would move the first interrupt to a different tick count. That error is visible on irq within 2^(k+1) ticks, or at once on sel_rdata. A fault in edge detection or in the sticky flag would appear on the very next edge of the selected bit, or on the cycle of a clear.

// File: rtl/btt_pkg.sv
package btt_pkg;
   localparam int BTT_DEF_CNT_W    = 32;
   localparam int BTT_DEF_SYNC_LAT = 2;
   localparam int BTT_MAX_CNT_W    = 64;
endpackage

// File: rtl/btt_run_sync.sv
module btt_run_sync #(
   parameter int SYNC_LAT = btt_pkg::BTT_DEF_SYNC_LAT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic req,
   output logic running
);
   if (SYNC_LAT < 1) begin : g_bad_lat
      $error("btt_run_sync: SYNC_LAT must be at least 1");
   end

   if (SYNC_LAT == 1) begin : g_single
      logic run_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     run_q <= 1'b0;
         else if (tick)  run_q <= req;
      end
      assign running = run_q;
   end else begin : g_chain
      logic [SYNC_LAT-1:0] stage_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    stage_q <= '0;
         else if (tick) stage_q <= {stage_q[SYNC_LAT-2:0], req};
      end
      assign running = stage_q[SYNC_LAT-1];
   end

   // R2
   run_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(running));
endmodule

// File: rtl/btt_count_core.sv
module btt_count_core #(
   parameter int CNT_W = btt_pkg::BTT_DEF_CNT_W,
   localparam int SEL_W = $clog2(CNT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             running,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   output logic [CNT_W-1:0] count,
   output logic [SEL_W-1:0] sel,
   output logic             step
);
   if (CNT_W < 2 || CNT_W > btt_pkg::BTT_MAX_CNT_W) begin : g_bad_w
      $error("btt_count_core: CNT_W out of range");
   end

   logic [CNT_W-1:0] count_q;
   logic [SEL_W-1:0] sel_q;

   assign step = running & tick;

   always_ff @(posedge clk) begin
      if (!rst_n)    count_q <= '0;
      else if (step) count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 sel_q <= '0;
      else if (sel_wr && !running) sel_q <= sel_wdata;
   end

   assign count = count_q;
   assign sel   = sel_q;

   // R4
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count_q));
   // R5
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (&count_q)) |=> (count_q == '0));
   // R8
   sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> $stable(sel_q));
endmodule

// File: rtl/btt_irq_flag.sv
module btt_irq_flag #(
   parameter int CNT_W = btt_pkg::BTT_DEF_CNT_W,
   localparam int SEL_W = $clog2(CNT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] count,
   input  logic [SEL_W-1:0] sel,
   input  logic             clr,
   output logic             irq
);
   logic [CNT_W-1:0] count_nxt;
   logic             bit_rise;
   logic             irq_q;

   assign count_nxt = count + 1'b1;
   assign bit_rise  = step & count_nxt[sel] & ~count[sel];

   always_ff @(posedge clk) begin
      if (!rst_n)        irq_q <= 1'b0;
      else if (bit_rise) irq_q <= 1'b1;
      else if (clr)      irq_q <= 1'b0;
   end

   assign irq = irq_q;

   // R7
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr) |=> irq_q);
   // R6
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(step));
endmodule

// File: rtl/bit_toggle_timer.sv
module bit_toggle_timer #(
   parameter int CNT_W    = btt_pkg::BTT_DEF_CNT_W,
   parameter int SYNC_LAT = btt_pkg::BTT_DEF_SYNC_LAT,
   localparam int SEL_W   = $clog2(CNT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lf_tick,
   input  logic             run_req,
   output logic             run_status,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   output logic [SEL_W-1:0] sel_rdata,
   output logic [CNT_W-1:0] count_rdata,
   input  logic             irq_clr,
   output logic             irq
);
   logic running;
   logic step;

   btt_run_sync #(.SYNC_LAT(SYNC_LAT)) u_sync (
      .clk(clk), .rst_n(rst_n), .tick(lf_tick), .req(run_req), .running(running)
   );

   btt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(lf_tick), .running(running),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata),
      .count(count_rdata), .sel(sel_rdata), .step(step)
   );

   btt_irq_flag #(.CNT_W(CNT_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .step(step), .count(count_rdata),
      .sel(sel_rdata), .clr(irq_clr), .irq(irq)
   );

   assign run_status = running;

   // R3
   run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && run_req) |=> running);
endmodule

// File: tb/bit_toggle_timer_tb.sv
module bit_toggle_timer_tb;
   localparam int W  = 32;
   localparam int SW = 5;
   localparam int SMW = 8;
   localparam int SMS = 3;
   localparam int NVEC = 7;
   localparam int unsigned SEL_TAB [NVEC] = '{0, 1, 3, 5, 8, 12, 2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic req = 1'b0, wr = 1'b0, clr = 1'b0;
   logic [SW-1:0] wdata = '0;
   logic status, irq;
   logic [SW-1:0] sel_rd;
   logic [W-1:0] cnt;

   logic req_s = 1'b0, wr_s = 1'b0, clr_s = 1'b0;
   logic [SMS-1:0] wdata_s = '0;
   logic status_s, irq_s;
   logic [SMS-1:0] sel_rd_s;
   logic [SMW-1:0] cnt_s;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   bit_toggle_timer #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .lf_tick(tick), .run_req(req), .run_status(status),
      .sel_wr(wr), .sel_wdata(wdata), .sel_rdata(sel_rd), .count_rdata(cnt),
      .irq_clr(clr), .irq(irq));

   bit_toggle_timer #(.CNT_W(SMW)) u_small (
      .clk(clk), .rst_n(rst_n), .lf_tick(tick), .run_req(req_s), .run_status(status_s),
      .sel_wr(wr_s), .sel_wdata(wdata_s), .sel_rdata(sel_rd_s), .count_rdata(cnt_s),
      .irq_clr(clr_s), .irq(irq_s));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic stop_dut();
      req = 1'b0;
      edges(2);
   endtask

   task automatic write_sel(input logic [SW-1:0] v);
      wr = 1'b1; wdata = v;
      edges(1);
      wr = 1'b0;
   endtask

   function automatic int next_rise(input logic [W-1:0] c, input int k);
      for (int n = 1; n <= (2 << k); n++) begin
         logic [W-1:0] a, b;
         a = c + W'(n - 1);
         b = c + W'(n);
         if (b[k] && !a[k]) return n;
      end
      return -1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [W-1:0] c0;
      int n;
      edges(3);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 count", cnt, 0);
      chk("R1 status", status, 0);
      chk("R1 sel", sel_rd, 0);
      chk("R1 irq", irq, 0);

      // R2 enable latency
      req = 1'b1;
      edges(1);
      chk("R2 status after 1 tick", status, 0);
      edges(1);
      chk("R2 status after 2 ticks", status, 1);
      chk("R2 count not yet advanced", cnt, 0);
      edges(1);
      chk("R2 first advance", cnt, 1);

      // R4 hold without tick, advance with tick
      tick = 1'b0;
      edges(5);
      chk("R4 hold no tick", cnt, 1);
      tick = 1'b1;
      edges(3);
      chk("R4 advance per tick", cnt, 4);

      // R8 write while running ignored
      write_sel(5'd9);
      chk("R8 sel locked while running", sel_rd, 0);

      // R3 disable latency
      c0 = cnt;
      req = 1'b0;
      edges(1);
      chk("R3 status still high 1", status, 1);
      edges(1);
      chk("R3 status low after 2", status, 0);
      edges(3);
      chk("R3 count advanced two then held", cnt, c0 + 2);

      // R8 write while stopped accepted
      write_sel(5'd9);
      chk("R8 sel accepted when stopped", sel_rd, 9);
      clr = 1'b1; edges(1); clr = 1'b0;
      chk("R7 clear", irq, 0);

      // R6 table walk: first interrupt timing per select value
      for (int i = 0; i < NVEC; i++) begin
         write_sel(SW'(SEL_TAB[i]));
         clr = 1'b1; edges(1); clr = 1'b0;
         c0 = cnt;
         n = next_rise(c0, SEL_TAB[i]);
         req = 1'b1;
         edges(2 + n - 1);
         chk($sformatf("R6 no early irq sel=%0d", SEL_TAB[i]), irq, 0);
         edges(1);
         chk($sformatf("R6 irq on rise sel=%0d", SEL_TAB[i]), irq, 1);
         chk($sformatf("R6 count at rise sel=%0d", SEL_TAB[i]), cnt, c0 + W'(n));
         edges(4);
         chk($sformatf("R7 sticky sel=%0d", SEL_TAB[i]), irq, 1);
         stop_dut();
      end

      // R7 clear colliding with rise; R6 no set on fall
      write_sel(5'd0);
      clr = 1'b1; edges(1); clr = 1'b0;
      req = 1'b1;
      edges(2);
      if (cnt[0]) edges(1);
      clr = 1'b1;
      edges(1);
      chk("R7 rise beats clear", irq, 1);
      edges(1);
      chk("R7 clear on fall", irq, 0);
      clr = 1'b0;
      chk("R6 bit0 now low", cnt[0], 0);
      edges(1);
      chk("R6 next rise sets", irq, 1);
      stop_dut();

      // R5 wrap on narrow instance, R6 top bit
      wr_s = 1'b1; wdata_s = 3'd7;
      edges(1);
      wr_s = 1'b0;
      chk("R8 small sel", sel_rd_s, 7);
      req_s = 1'b1;
      edges(2 + 127);
      chk("R6 top bit no early irq", irq_s, 0);
      edges(1);
      chk("R6 top bit irq", irq_s, 1);
      chk("R6 top bit count", cnt_s, 8'h80);
      clr_s = 1'b1; edges(1); clr_s = 1'b0;
      edges(126);
      chk("R5 at all ones", cnt_s, 8'hFF);
      edges(1);
      chk("R5 wrapped to zero", cnt_s, 8'h00);
      chk("R6 no irq on wrap fall", irq_s, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule